// File: doc/BRIEF.md
# DMA Global Control and Status Registers

This block is the shared register bank of a DMA controller with up to 64 channels. Software reaches it through a word-wide write port and a combinational read port. For each channel it keeps four masks: hardware request enable, error interrupt enable, interrupt pending and error pending. Each mask is read and written as two 32-bit words. The upper word holds channels 63 to 32 and the lower word holds channels 31 to 0.

Software does not have to read, modify and write a whole mask word to change one channel. Seven shortcut registers each take a channel index in the low byte of the written data, and each acts on that one channel only. They set or clear a request enable, set or clear an error interrupt enable, clear an interrupt pending bit, clear an error pending bit, or send a one-cycle start pulse to the channel.

The channel engines report completion and error events on per-channel strobes. They also report a detailed error record, which the block latches as a status word. Only the first error is kept. A valid flag marks the word, and the word holds until software clears it. A small control register holds the arbitration and clocking choices and drives them to the arbiter. One interrupt output combines every pending event that software has allowed.

Top module: `dma_gr_regs`

## Requirements
- R1: After a synchronous reset, every mask, the error status word and the control register read zero, and `irq` is low.
- R2: The request-enable and error-interrupt-enable masks can be written and read as whole words. The upper word is at offset 2 or 4 and holds channels 63..32. The lower word is at offset 3 or 5 and holds channels 31..0. `req_en` shows the request-enable mask.
- R3: Writing channel index N (`wr_data[7:0]`) to offset 6 sets request-enable bit N, and writing it to offset 7 clears that bit. No other bit changes.
- R4: Writing N to offset 8 sets error-interrupt-enable bit N, and writing N to offset 9 clears it.
- R5: A high `evt_done[N]` sets interrupt-pending bit N, read at offset 13 (upper word) and 14 (lower word). A high `evt_err[N]` sets error-pending bit N, read at offset 15 (upper) and 16 (lower). Writing N to offset 10 clears interrupt-pending bit N, and writing N to offset 11 clears error-pending bit N.
- R6: Writing a word to a pending-mask offset (13 to 16) clears each bit written as one and leaves every bit written as zero. An all-ones write clears the whole word.
- R7: If a channel's completion or error event comes in the same cycle as a software clear of that channel's pending bit, by index or by word, the bit ends up set.
- R8: Writing N to offset 12 drives `start_pulse[N]` high for exactly one cycle, the cycle after the write. No other start bit goes high.
- R9: An error report with the status word invalid latches {bit 31 valid, bit 15 group-priority error, bit 14 channel-priority error, bits 13:8 channel, bits 7:0 cause}. The word is read at offset 1. `err_rpt_flags[9]` and `err_rpt_flags[8]` carry the two priority errors, and `err_rpt_flags[7:0]` carries the cause bits. Later reports do not change a valid word.
- R10: A write to offset 11 also clears the error status word. A report in the same cycle is then latched as the new first error.
- R11: The control register is at offset 0. It stores bit 2 (round-robin channel arbitration), bit 3 (round-robin group arbitration) and bit 31 (dynamic clocking), drives them to `arb_rr_chan`, `arb_rr_grp` and `dyn_clk_en`, and reads every other bit as zero.
- R12: `irq` is high while any interrupt-pending bit is set, or while any error-pending bit is set whose error-interrupt enable is also set.
- R13: A shortcut write whose index byte is NUM_CH or larger changes nothing. This holds even when the low six bits of the index name a real channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Word offset of the write |
| wr_data | input | 32 | Write data; the low byte is the channel index for shortcut registers |
| rd_addr | input | 5 | Word offset of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| evt_done | input | NUM_CH | Per-channel completion strobes |
| evt_err | input | NUM_CH | Per-channel error strobes |
| err_rpt_vld | input | 1 | Detailed error report valid |
| err_rpt_chan | input | 6 | Channel named in the error report |
| err_rpt_flags | input | 10 | Group priority, channel priority, eight cause bits |
| req_en | output | NUM_CH | Hardware request-enable mask |
| start_pulse | output | NUM_CH | One-cycle software start per channel |
| arb_rr_chan | output | 1 | Round-robin channel arbitration selected |
| arb_rr_grp | output | 1 | Round-robin group arbitration selected |
| dyn_clk_en | output | 1 | Dynamic clocking selected |
| irq | output | 1 | Combined interrupt |

## Verification
The bench drives the cases where a clear and a new event for the same channel land in the same cycle. A design that gave the clear priority would lose the completion, and the pending bit would read zero. It writes index bytes of 64 and above whose low six bits match a live channel. A decoder that cut the index down to six bits would wrongly clear or set that channel. It sends a second error report while a first one is still held. An overwriting status register would show the later channel and cause. The bench also sends a report in the same cycle as the clear-error write, where a design that applied the clear last would drop the report. An error-pending bit on a channel whose error-interrupt enable is off must leave `irq` low, which catches a design that ORs the raw error mask into the interrupt.

// File: rtl/dma_gr_pkg.sv
package dma_gr_pkg;

    localparam int WORD_W = 32;
    localparam int MASK_W = 64;
    localparam int IDX_W  = 6;
    localparam int ADDR_W = 5;

    localparam int CTRL_RR_CH_BIT  = 2;
    localparam int CTRL_RR_GRP_BIT = 3;
    localparam int CTRL_DYN_BIT    = 31;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL    = 5'd0,
        RA_ESTAT   = 5'd1,
        RA_REQ_HI  = 5'd2,
        RA_REQ_LO  = 5'd3,
        RA_EIE_HI  = 5'd4,
        RA_EIE_LO  = 5'd5,
        RA_SET_REQ = 5'd6,
        RA_CLR_REQ = 5'd7,
        RA_SET_EIE = 5'd8,
        RA_CLR_EIE = 5'd9,
        RA_CLR_INT = 5'd10,
        RA_CLR_ERR = 5'd11,
        RA_START   = 5'd12,
        RA_INT_HI  = 5'd13,
        RA_INT_LO  = 5'd14,
        RA_ERR_HI  = 5'd15,
        RA_ERR_LO  = 5'd16
    } reg_addr_e;

    // Decoded write strobes; two-bit fields are {upper word, lower word}
    typedef struct packed {
        logic       ld_ctrl;
        logic [1:0] ld_req;
        logic [1:0] ld_eie;
        logic [1:0] w1c_int;
        logic [1:0] w1c_err;
        logic       set_req;
        logic       clr_req;
        logic       set_eie;
        logic       clr_eie;
        logic       clr_int;
        logic       clr_err;
        logic       start;
    } wr_strb_t;

    typedef struct packed {
        logic       grp_prio;
        logic       ch_prio;
        logic [7:0] cause;
    } err_flags_t;

    typedef struct packed {
        logic             valid;
        logic [14:0]      rsvd;
        logic             grp_prio;
        logic             ch_prio;
        logic [IDX_W-1:0] chan;
        logic [7:0]       cause;
    } estat_t;

    typedef struct packed {
        logic dyn_clk;
        logic rr_grp;
        logic rr_ch;
    } ctrl_t;

    function automatic logic [MASK_W-1:0] idx_onehot(logic [7:0] idx, int unsigned nch);
        logic [MASK_W-1:0] r;
        r = '0;
        if (32'(idx) < nch) r[idx[IDX_W-1:0]] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/dma_gr_wdec.sv
module dma_gr_wdec
    import dma_gr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          wr_idx,
    output wr_strb_t            strb,
    output logic [MASK_W-1:0]   sel
);

    assign sel = idx_onehot(wr_idx, NUM_CH);

    always_comb begin
        strb = '0;
        if (wr_en) begin
            case (wr_addr)
                RA_CTRL:    strb.ld_ctrl    = 1'b1;
                RA_REQ_HI:  strb.ld_req[1]  = 1'b1;
                RA_REQ_LO:  strb.ld_req[0]  = 1'b1;
                RA_EIE_HI:  strb.ld_eie[1]  = 1'b1;
                RA_EIE_LO:  strb.ld_eie[0]  = 1'b1;
                RA_SET_REQ: strb.set_req    = 1'b1;
                RA_CLR_REQ: strb.clr_req    = 1'b1;
                RA_SET_EIE: strb.set_eie    = 1'b1;
                RA_CLR_EIE: strb.clr_eie    = 1'b1;
                RA_CLR_INT: strb.clr_int    = 1'b1;
                RA_CLR_ERR: strb.clr_err    = 1'b1;
                RA_START:   strb.start      = 1'b1;
                RA_INT_HI:  strb.w1c_int[1] = 1'b1;
                RA_INT_LO:  strb.w1c_int[0] = 1'b1;
                RA_ERR_HI:  strb.w1c_err[1] = 1'b1;
                RA_ERR_LO:  strb.w1c_err[0] = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dma_gr_mask.sv
module dma_gr_mask
    import dma_gr_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter bit W1C    = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [MASK_W-1:0]  hw_set,
    input  logic [MASK_W-1:0]  idx_set,
    input  logic [MASK_W-1:0]  idx_clr,
    input  logic [1:0]         word_wr,
    input  logic [WORD_W-1:0]  word_data,
    output logic [MASK_W-1:0]  q
);

    for (genvar g = 0; g < MASK_W; g++) begin : g_bit
        if (g < NUM_CH) begin : g_live
            localparam int WI = g / WORD_W;
            localparam int BI = g % WORD_W;
            logic b;
            // Hardware event beats any software clear of the same bit
            always_ff @(posedge clk) begin
                if (rst)                b <= 1'b0;
                else if (hw_set[g])     b <= 1'b1;
                else if (idx_clr[g])    b <= 1'b0;
                else if (idx_set[g])    b <= 1'b1;
                else if (word_wr[WI]) begin
                    if (W1C) begin
                        if (word_data[BI]) b <= 1'b0;
                    end else begin
                        b <= word_data[BI];
                    end
                end
            end
            assign q[g] = b;
        end else begin : g_dead
            assign q[g] = 1'b0;
        end
    end

endmodule

// File: rtl/dma_gr_estat.sv
module dma_gr_estat
    import dma_gr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rpt_vld,
    input  logic [IDX_W-1:0] rpt_chan,
    input  err_flags_t       rpt_flags,
    output estat_t           q
);

    estat_t nxt;

    always_comb begin
        nxt = clr ? '0 : q;
        if (!nxt.valid && rpt_vld) begin
            nxt          = '0;
            nxt.valid    = 1'b1;
            nxt.grp_prio = rpt_flags.grp_prio;
            nxt.ch_prio  = rpt_flags.ch_prio;
            nxt.chan     = rpt_chan;
            nxt.cause    = rpt_flags.cause;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/dma_gr_regs.sv
module dma_gr_regs
    import dma_gr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [WORD_W-1:0]       rd_data,
    input  logic [NUM_CH-1:0]       evt_done,
    input  logic [NUM_CH-1:0]       evt_err,
    input  logic                    err_rpt_vld,
    input  logic [IDX_W-1:0]        err_rpt_chan,
    input  logic [9:0]              err_rpt_flags,
    output logic [NUM_CH-1:0]       req_en,
    output logic [NUM_CH-1:0]       start_pulse,
    output logic                    arb_rr_chan,
    output logic                    arb_rr_grp,
    output logic                    dyn_clk_en,
    output logic                    irq
);

    wr_strb_t          strb;
    logic [MASK_W-1:0] sel;
    logic [MASK_W-1:0] req_q, eie_q, int_q, err_q;
    logic [MASK_W-1:0] done_w, err_w, start_q;
    estat_t            estat_q;
    ctrl_t             ctrl_q;

    always_comb begin
        done_w = '0;
        err_w  = '0;
        done_w[NUM_CH-1:0] = evt_done;
        err_w[NUM_CH-1:0]  = evt_err;
    end

    dma_gr_wdec #(.NUM_CH(NUM_CH)) u_wdec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_idx (wr_data[7:0]),
        .strb   (strb),
        .sel    (sel)
    );

    dma_gr_mask #(.NUM_CH(NUM_CH), .W1C(1'b0)) u_req (
        .clk(clk), .rst(rst),
        .hw_set   ('0),
        .idx_set  (strb.set_req ? sel : '0),
        .idx_clr  (strb.clr_req ? sel : '0),
        .word_wr  (strb.ld_req),
        .word_data(wr_data),
        .q        (req_q)
    );

    dma_gr_mask #(.NUM_CH(NUM_CH), .W1C(1'b0)) u_eie (
        .clk(clk), .rst(rst),
        .hw_set   ('0),
        .idx_set  (strb.set_eie ? sel : '0),
        .idx_clr  (strb.clr_eie ? sel : '0),
        .word_wr  (strb.ld_eie),
        .word_data(wr_data),
        .q        (eie_q)
    );

    dma_gr_mask #(.NUM_CH(NUM_CH), .W1C(1'b1)) u_int (
        .clk(clk), .rst(rst),
        .hw_set   (done_w),
        .idx_set  ('0),
        .idx_clr  (strb.clr_int ? sel : '0),
        .word_wr  (strb.w1c_int),
        .word_data(wr_data),
        .q        (int_q)
    );

    dma_gr_mask #(.NUM_CH(NUM_CH), .W1C(1'b1)) u_err (
        .clk(clk), .rst(rst),
        .hw_set   (err_w),
        .idx_set  ('0),
        .idx_clr  (strb.clr_err ? sel : '0),
        .word_wr  (strb.w1c_err),
        .word_data(wr_data),
        .q        (err_q)
    );

    dma_gr_estat u_estat (
        .clk      (clk),
        .rst      (rst),
        .clr      (strb.clr_err),
        .rpt_vld  (err_rpt_vld),
        .rpt_chan (err_rpt_chan),
        .rpt_flags(err_flags_t'(err_rpt_flags)),
        .q        (estat_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            start_q <= '0;
        end else begin
            if (strb.ld_ctrl) begin
                ctrl_q.dyn_clk <= wr_data[CTRL_DYN_BIT];
                ctrl_q.rr_grp  <= wr_data[CTRL_RR_GRP_BIT];
                ctrl_q.rr_ch   <= wr_data[CTRL_RR_CH_BIT];
            end
            start_q <= strb.start ? sel : '0;
        end
    end

    assign req_en      = req_q[NUM_CH-1:0];
    assign start_pulse = start_q[NUM_CH-1:0];
    assign arb_rr_chan = ctrl_q.rr_ch;
    assign arb_rr_grp  = ctrl_q.rr_grp;
    assign dyn_clk_en  = ctrl_q.dyn_clk;
    assign irq         = (|int_q) | (|(err_q & eie_q));

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTRL: begin
                rd_data[CTRL_DYN_BIT]    = ctrl_q.dyn_clk;
                rd_data[CTRL_RR_GRP_BIT] = ctrl_q.rr_grp;
                rd_data[CTRL_RR_CH_BIT]  = ctrl_q.rr_ch;
            end
            RA_ESTAT:  rd_data = estat_q;
            RA_REQ_HI: rd_data = req_q[MASK_W-1:WORD_W];
            RA_REQ_LO: rd_data = req_q[WORD_W-1:0];
            RA_EIE_HI: rd_data = eie_q[MASK_W-1:WORD_W];
            RA_EIE_LO: rd_data = eie_q[WORD_W-1:0];
            RA_INT_HI: rd_data = int_q[MASK_W-1:WORD_W];
            RA_INT_LO: rd_data = int_q[WORD_W-1:0];
            RA_ERR_HI: rd_data = err_q[MASK_W-1:WORD_W];
            RA_ERR_LO: rd_data = err_q[WORD_W-1:0];
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dma_gr_regs_chk.sv
module dma_gr_regs_chk
    import dma_gr_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [7:0]         wr_idx,
    input logic [MASK_W-1:0]  req_q,
    input logic [MASK_W-1:0]  int_q,
    input logic [MASK_W-1:0]  done_w,
    input logic [WORD_W-1:0]  estat_w,
    input logic [NUM_CH-1:0]  start_pulse
);

    logic [IDX_W-1:0]  idx_d;
    logic [MASK_W-1:0] done_d;

    always_ff @(posedge clk) begin
        idx_d  <= wr_idx[IDX_W-1:0];
        done_d <= done_w;
    end

    a_r3_set_req: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == RA_SET_REQ && 32'(wr_idx) < NUM_CH) |=> req_q[idx_d]);

    a_r3_clr_req: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == RA_CLR_REQ && 32'(wr_idx) < NUM_CH) |=> !req_q[idx_d]);

    a_r13_bad_index: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == RA_SET_REQ || wr_addr == RA_CLR_REQ) && 32'(wr_idx) >= NUM_CH)
        |=> $stable(req_q));

    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
        (done_w != '0) |=> ((int_q & done_d) == done_d));

    a_r9_first_kept: assert property (@(posedge clk) disable iff (rst)
        (estat_w[31] && !(wr_en && wr_addr == RA_CLR_ERR)) |=> $stable(estat_w));

    a_r8_start_single: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_pulse));

    a_r8_start_cause: assert property (@(posedge clk) disable iff (rst)
        (start_pulse != '0) |-> $past(wr_en && wr_addr == RA_START));

endmodule

bind dma_gr_regs dma_gr_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_idx     (wr_data[7:0]),
    .req_q      (req_q),
    .int_q      (int_q),
    .done_w     (done_w),
    .estat_w    (estat_q),
    .start_pulse(start_pulse)
);

// File: tb/test_dma_gr_regs.sv
module test_dma_gr_regs;
    import dma_gr_pkg::*;

    localparam int NCH = 64;
    localparam int K_RD = 0, K_IRQ = 1, K_START = 2, K_CTRL = 3, K_REQ = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [4:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [4:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic [NCH-1:0]    evt_done = '0;
    logic [NCH-1:0]    evt_err = '0;
    logic              err_rpt_vld = 1'b0;
    logic [5:0]        err_rpt_chan = '0;
    logic [9:0]        err_rpt_flags = '0;
    logic [NCH-1:0]    req_en, start_pulse;
    logic              arb_rr_chan, arb_rr_grp, dyn_clk_en, irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int          q_kind[$];
    logic [4:0]  q_addr[$];
    logic [63:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    dma_gr_regs #(.NUM_CH(NCH)) i_dma_gr_regs (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_done(evt_done), .evt_err(evt_err),
        .err_rpt_vld(err_rpt_vld), .err_rpt_chan(err_rpt_chan), .err_rpt_flags(err_rpt_flags),
        .req_en(req_en), .start_pulse(start_pulse),
        .arb_rr_chan(arb_rr_chan), .arb_rr_grp(arb_rr_grp), .dyn_clk_en(dyn_clk_en),
        .irq(irq)
    );

    // Monitor: pops one expected item per cycle and compares it
    always @(negedge clk) begin
        int          k;
        logic [63:0] got;
        logic [63:0] e;
        string       t;
        #2;
        if (q_kind.size() > 0) begin
            k = q_kind.pop_front();
            rd_addr = q_addr.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            #1;
            case (k)
                K_RD:    got = {32'b0, rd_data};
                K_IRQ:   got = {63'b0, irq};
                K_START: got = start_pulse;
                K_CTRL:  got = {61'b0, dyn_clk_en, arb_rr_grp, arb_rr_chan};
                default: got = req_en;
            endcase
            checks++;
            if (got !== e) begin
                errors++;
                $display("FAIL %s got %h exp %h", t, got, e);
            end
        end
    end

    task automatic push(int k, logic [4:0] a, logic [63:0] e, string t);
        q_kind.push_back(k);
        q_addr.push_back(a);
        q_exp.push_back(e);
        q_tag.push_back(t);
    endtask

    task automatic exp_rd(logic [4:0] a, logic [31:0] e, string t);
        push(K_RD, a, {32'b0, e}, t);
    endtask

    task automatic settle();
        while (q_kind.size() != 0) @(negedge clk);
        #4;
    endtask

    task automatic drive(bit we, logic [4:0] a, logic [31:0] d,
                         logic [NCH-1:0] dn, logic [NCH-1:0] er,
                         bit rv, logic [5:0] rc, logic [9:0] rf);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        evt_done = dn; evt_err = er;
        err_rpt_vld = rv; err_rpt_chan = rc; err_rpt_flags = rf;
        @(negedge clk);
        wr_en = 1'b0; evt_done = '0; evt_err = '0; err_rpt_vld = 1'b0;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        drive(1'b1, a, d, '0, '0, 1'b0, '0, '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R1 got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        exp_rd(RA_CTRL, 32'h0, "R1 ctrl");
        exp_rd(RA_ESTAT, 32'h0, "R1 estat");
        exp_rd(RA_REQ_LO, 32'h0, "R1 req lo");
        exp_rd(RA_INT_HI, 32'h0, "R1 int hi");
        push(K_IRQ, 0, 64'h0, "R1 irq");
        settle();

        // R2 word access
        wr(RA_REQ_HI, 32'hA5A5_0001);
        wr(RA_REQ_LO, 32'h8000_0002);
        exp_rd(RA_REQ_HI, 32'hA5A5_0001, "R2 req hi");
        exp_rd(RA_REQ_LO, 32'h8000_0002, "R2 req lo");
        push(K_REQ, 0, 64'hA5A5_0001_8000_0002, "R2 req_en port");
        settle();

        // R3 index set and clear
        wr(RA_SET_REQ, 32'd4);
        wr(RA_SET_REQ, 32'd40);
        wr(RA_CLR_REQ, 32'd63);
        wr(RA_CLR_REQ, 32'd1);
        exp_rd(RA_REQ_LO, 32'h8000_0010, "R3 req lo");
        exp_rd(RA_REQ_HI, 32'h25A5_0101, "R3 req hi");
        push(K_REQ, 0, 64'h25A5_0101_8000_0010, "R3 req_en port");
        settle();

        // R13 out-of-range index bytes
        wr(RA_SET_REQ, 32'd64);
        wr(RA_SET_REQ, 32'd255);
        wr(RA_CLR_REQ, 32'd68);
        exp_rd(RA_REQ_LO, 32'h8000_0010, "R13 req lo unchanged");
        exp_rd(RA_REQ_HI, 32'h25A5_0101, "R13 req hi unchanged");
        settle();
        wr(RA_START, 32'd200);
        push(K_START, 0, 64'h0, "R13 no start");
        settle();

        // R4 error interrupt enable
        wr(RA_SET_EIE, 32'd33);
        wr(RA_SET_EIE, 32'd2);
        exp_rd(RA_EIE_HI, 32'h2, "R4 eie hi");
        exp_rd(RA_EIE_LO, 32'h4, "R4 eie lo set");
        settle();
        wr(RA_CLR_EIE, 32'd2);
        exp_rd(RA_EIE_LO, 32'h0, "R4 eie lo clr");
        settle();
        wr(RA_EIE_LO, 32'h0000_0100);
        exp_rd(RA_EIE_LO, 32'h0000_0100, "R2 eie lo word");
        settle();

        // R5 events and index clears, R12 irq
        drive(1'b0, 0, 0, (64'd1 << 3) | (64'd1 << 35), '0, 1'b0, '0, '0);
        exp_rd(RA_INT_LO, 32'h8, "R5 int lo");
        exp_rd(RA_INT_HI, 32'h8, "R5 int hi");
        push(K_IRQ, 0, 64'h1, "R12 irq from int");
        settle();
        drive(1'b0, 0, 0, '0, (64'd1 << 8) | (64'd1 << 40), 1'b0, '0, '0);
        exp_rd(RA_ERR_LO, 32'h100, "R5 err lo");
        exp_rd(RA_ERR_HI, 32'h100, "R5 err hi");
        settle();
        wr(RA_CLR_INT, 32'd3);
        wr(RA_CLR_INT, 32'd35);
        exp_rd(RA_INT_LO, 32'h0, "R5 int lo clr");
        exp_rd(RA_INT_HI, 32'h0, "R5 int hi clr");
        push(K_IRQ, 0, 64'h1, "R12 irq from enabled err");
        settle();
        wr(RA_CLR_ERR, 32'd8);
        exp_rd(RA_ERR_LO, 32'h0, "R5 err lo clr");
        exp_rd(RA_ERR_HI, 32'h100, "R5 err hi kept");
        push(K_IRQ, 0, 64'h0, "R12 masked err no irq");
        settle();

        // R6 write-one-to-clear words
        drive(1'b0, 0, 0, '1, '0, 1'b0, '0, '0);
        exp_rd(RA_INT_HI, 32'hFFFF_FFFF, "R6 int hi full");
        settle();
        wr(RA_INT_LO, 32'h0000_FFFF);
        exp_rd(RA_INT_LO, 32'hFFFF_0000, "R6 int lo partial");
        settle();
        wr(RA_INT_LO, 32'hFFFF_FFFF);
        wr(RA_INT_HI, 32'hFFFF_FFFF);
        wr(RA_ERR_HI, 32'h0000_0100);
        exp_rd(RA_INT_LO, 32'h0, "R6 int lo all clr");
        exp_rd(RA_INT_HI, 32'h0, "R6 int hi all clr");
        exp_rd(RA_ERR_HI, 32'h0, "R6 err hi clr");
        push(K_IRQ, 0, 64'h0, "R12 irq idle");
        settle();

        // R7 event beats same-cycle clear
        drive(1'b1, RA_CLR_INT, 32'd5, 64'd1 << 5, '0, 1'b0, '0, '0);
        exp_rd(RA_INT_LO, 32'h20, "R7 index clr loses");
        settle();
        drive(1'b1, RA_INT_LO, 32'hFFFF_FFFF, 64'd1 << 6, '0, 1'b0, '0, '0);
        exp_rd(RA_INT_LO, 32'h40, "R7 word clr loses");
        settle();
        wr(RA_INT_LO, 32'hFFFF_FFFF);

        // R8 start pulse
        wr(RA_START, 32'd9);
        push(K_START, 0, 64'd1 << 9, "R8 start 9");
        settle();
        push(K_START, 0, 64'h0, "R8 start one cycle");
        settle();
        wr(RA_START, 32'd50);
        push(K_START, 0, 64'd1 << 50, "R8 start 50");
        settle();

        // R9 first error capture
        drive(1'b0, 0, 0, '0, '0, 1'b1, 6'd12, 10'h205);
        exp_rd(RA_ESTAT, 32'h8000_8C05, "R9 capture");
        settle();
        drive(1'b0, 0, 0, '0, '0, 1'b1, 6'd20, 10'h3FF);
        exp_rd(RA_ESTAT, 32'h8000_8C05, "R9 first kept");
        settle();

        // R10 clear and same-cycle report
        wr(RA_CLR_ERR, 32'd0);
        exp_rd(RA_ESTAT, 32'h0, "R10 cleared");
        settle();
        drive(1'b1, RA_CLR_ERR, 32'd0, '0, '0, 1'b1, 6'd7, 10'h100);
        exp_rd(RA_ESTAT, 32'h8000_4700, "R10 report with clear");
        settle();

        // R11 control register
        wr(RA_CTRL, 32'hFFFF_FFFF);
        exp_rd(RA_CTRL, 32'h8000_000C, "R11 ctrl all");
        push(K_CTRL, 0, 64'h7, "R11 ctrl outputs all");
        settle();
        wr(RA_CTRL, 32'h0000_0004);
        exp_rd(RA_CTRL, 32'h0000_0004, "R11 ctrl rr chan");
        push(K_CTRL, 0, 64'h1, "R11 ctrl outputs chan");
        settle();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule